// File: doc/BRIEF.md
# Atomic 16-bit Register Access Bridge

This block sits between an 8-bit CPU data bus and a group of 16-bit peripheral registers: a free-running counter, a compare value and a capture value. A CPU can move only one byte per access, so a 16-bit value would otherwise change or be sampled half at a time. The bridge prevents this with one shared 8-bit holding byte. For a write, the CPU writes the upper byte first, and the bridge only parks it. The lower-byte write then issues a single 16-bit load to the target. For a read, the CPU reads the lower byte first. That access also snapshots the upper byte of the same instant into the holding byte, and the following upper-byte read returns the snapshot.

The owner of each 16-bit register supplies its live value on a packed input and applies the load strobe at the clock edge where it is raised. A load from the bus overrides anything the owner would do to the register on that edge, such as the counter's own increment. Read data is registered and appears one clock after the read strobe. Because the holding byte is common to all registers, software must not interleave accesses to different registers. When it does, the value it gets is mixed.

Top module: `wide_reg_bridge`

## Requirements
- R1: A write with addr[0]=1 to a mapped register stores wdata in the holding byte and raises no load strobe.
- R2: A write with addr[0]=0 to mapped register k raises load_en[k] alone, combinationally in that cycle, with load_data = {holding byte, wdata}. The owner commits all 16 bits at that edge, so a lower-byte read in the next cycle returns the written low byte.
- R3: A read with addr[0]=0 of register k returns reg_val bits [7:0] of k on rdata one clock later, and the same edge copies bits [15:8] of k into the holding byte.
- R4: A read with addr[0]=1 returns the holding byte, not the live upper byte, on rdata one clock later.
- R5: The holding byte is shared by all registers, so an access to another register between the two halves of a sequence changes the outcome of that sequence.
- R6: Addresses whose register index (addr[2:1]) is not below N_REGS are ignored. Writes leave the holding byte untouched and raise no strobe, and reads return 0.
- R7: load_en is all zero in every cycle without a lower-byte write to a mapped register.
- R8: rdata holds its value in cycles with no read strobe.
- R9: After reset the holding byte and rdata are 0, so an upper-byte read with no prior access returns 0.

Register index map (addr[2:1]): 0 counter, 1 compare, 2 capture. addr[0] = 1 selects the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address: [0] upper/lower, rest register index |
| wdata | input | 8 | CPU write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read byte |
| reg_val | input | 16*N_REGS | Live values of the 16-bit registers, index k at bits [16k+15:16k] |
| load_en | output | N_REGS | One-hot load strobe per register |
| load_data | output | 16 | Value to load |

## Verification
The assertions assume that the CPU never raises wr_en and rd_en in the same cycle, and that reg_val changes only at clock edges. The bench issues each random transaction as either a read or a write, never both. It updates the counter, compare and capture models only on the rising edge, and drives the bus at the falling edge.

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int N_REGS = 3,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [7:0]            rdata,
  input  logic [16*N_REGS-1:0]  reg_val,
  output logic [N_REGS-1:0]     load_en,
  output logic [15:0]           load_data
);
  localparam int IDX_W = ADDR_W - 1;

  logic [7:0]       temp_q;
  logic [15:0]      sel_val;
  logic [IDX_W-1:0] idx;
  logic             hi, hit;

  assign idx = addr[ADDR_W-1:1];
  assign hi  = addr[0];
  assign hit = {1'b0, idx} < (IDX_W+1)'(N_REGS);

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < N_REGS; i++)
      if (idx == IDX_W'(i)) sel_val = reg_val[i*16 +: 16];
  end

  for (genvar g = 0; g < N_REGS; g++) begin : g_load
    assign load_en[g] = wr_en && !hi && (idx == IDX_W'(g));
  end

  assign load_data = {temp_q, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n)                       temp_q <= '0;
    else if (wr_en && hit && hi)      temp_q <= wdata;
    else if (rd_en && hit && !hi)     temp_q <= sel_val[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= !hit ? 8'h00 : (hi ? temp_q : sel_val[7:0]);
  end
endmodule

module wide_reg_bridge_chk #(
  parameter int N_REGS = 3,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic [7:0]           wdata,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [7:0]           rdata,
  input logic [16*N_REGS-1:0] reg_val,
  input logic [N_REGS-1:0]    load_en,
  input logic [15:0]          load_data,
  input logic [7:0]           temp_q
);
  localparam int IDX_W = ADDR_W - 1;
  logic [IDX_W-1:0] c_idx;
  logic             c_hit;
  logic [7:0]       c_upper;
  assign c_idx   = addr[ADDR_W-1:1];
  assign c_hit   = {1'b0, c_idx} < (IDX_W+1)'(N_REGS);
  assign c_upper = c_hit ? reg_val[int'(c_idx)*16 + 8 +: 8] : 8'h00;

  AST_HI_WR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[0] |-> load_en == '0); // R1
  AST_HI_WR_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[0] && c_hit |=> temp_q == $past(wdata)); // R1
  AST_LO_WR_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !addr[0] && c_hit |-> $countones(load_en) == 1 && load_data[7:0] == wdata); // R2
  AST_LO_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && !addr[0] && c_hit |=> temp_q == $past(c_upper)); // R3
  AST_HI_RD_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[0] && c_hit |=> rdata == $past(temp_q)); // R4
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !c_hit |=> $stable(temp_q)); // R6
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> load_en == '0); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .reg_val(reg_val), .load_en(load_en), .load_data(load_data), .temp_q(temp_q)
);

// File: tb/wide_reg_bridge_test.sv
module wide_reg_bridge_test;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  rdata;
  logic [47:0] reg_val;
  logic [2:0]  load_en;
  logic [15:0] load_data;
  logic [15:0] cnt_r, cmp_r, cap_r;
  logic [7:0]  temp_m = 0, last_rd = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wide_reg_bridge uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .reg_val(reg_val), .load_en(load_en), .load_data(load_data));

  assign reg_val = {cap_r, cmp_r, cnt_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin cnt_r <= 0; cmp_r <= 0; cap_r <= 0; end
    else begin
      cnt_r <= load_en[0] ? load_data : cnt_r + 16'd1;
      if (load_en[1]) cmp_r <= load_data;
      if (load_en[2]) cap_r <= load_data;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit is_wr, input logic [2:0] a);
    if (a[2:1] == 2'd3) return "R6";
    if (is_wr) return a[0] ? "R1" : "R2";
    return a[0] ? "R4" : "R3";
  endfunction

  task automatic op(input bit is_wr, input logic [2:0] a, input logic [7:0] d);
    int ix; bit mapped, hi; logic [15:0] v; logic [2:0] exp_en; string req;
    req = tag_of(is_wr, a);
    @(negedge clk);
    addr = a; wdata = d; wr_en = is_wr; rd_en = !is_wr;
    #1;
    ix = int'(a[2:1]); mapped = ix < 3; hi = a[0];
    v = mapped ? reg_val[ix*16 +: 16] : 16'h0;
    if (is_wr) begin
      exp_en = (mapped && !hi) ? (3'b001 << ix) : 3'b000;
      check(req, "load_en", 32'(load_en), 32'(exp_en));
      if (exp_en != 0) check(req, "load_data", 32'(load_data), {16'h0, temp_m, d});
      if (mapped && hi) temp_m = d;
    end else begin
      last_rd = !mapped ? 8'h00 : (hi ? temp_m : v[7:0]);
      if (mapped && !hi) temp_m = v[15:8];
    end
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    if (!is_wr) begin
      @(negedge clk);
      check(req, "rdata", 32'(rdata), 32'(last_rd));
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R9", "rdata after reset", 32'(rdata), 0);
    check("R7", "load_en idle", 32'(load_en), 0);
    op(0, 3'd1, 0);
    check("R9", "upper read after reset", 32'(rdata), 0);

    op(1, 3'd1, 8'h5A); op(1, 3'd0, 8'h3C);
    op(0, 3'd0, 0); check("R2", "counter low after load", 32'(rdata), 32'h3C);
    op(0, 3'd1, 0); check("R2", "counter high after load", 32'(rdata), 32'h5A);

    op(1, 3'd1, 8'h12); op(1, 3'd0, 8'hFE);
    op(0, 3'd0, 0); check("R3", "low byte snapshot", 32'(rdata), 32'hFE);
    repeat (4) @(negedge clk);
    op(0, 3'd1, 0); check("R4", "high read returns held byte", 32'(rdata), 32'h12);

    op(1, 3'd3, 8'h77); op(1, 3'd2, 8'h01);
    op(1, 3'd5, 8'h44); op(1, 3'd4, 8'h55);
    op(1, 3'd1, 8'hAB); op(1, 3'd3, 8'hCD); op(1, 3'd0, 8'h12);
    check("R5", "interleaved write mixes bytes", 32'(cnt_r), 32'hCD12);
    op(0, 3'd4, 0); op(0, 3'd2, 0); op(0, 3'd5, 0);
    check("R5", "interleaved read gets other high byte", 32'(rdata), 32'h77);

    op(1, 3'd1, 8'h9C); op(1, 3'd6, 8'hEE); op(1, 3'd7, 8'hEF);
    op(0, 3'd3, 0); check("R6", "unmapped write left holding byte", 32'(rdata), 32'h9C);
    op(0, 3'd7, 0); check("R6", "unmapped read", 32'(rdata), 0);

    repeat (3) begin
      @(negedge clk);
      check("R8", "rdata hold", 32'(rdata), 32'(last_rd));
      check("R7", "no load when idle", 32'(load_en), 0);
    end

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], r[3:1], r[11:4]);
      if (r[12]) begin
        @(negedge clk);
        check("R8", "rdata hold random", 32'(rdata), 32'(last_rd));
      end
    end
    summary();
  end
endmodule